// File: doc/BRIEF.md
# Selectable Bypass Sample FIFO

This block sits between a converter's result register and the output register that drives the pins. It holds up to 16 result words of 18 bits each: 16 data bits plus the sign (MSB) bit and the overflow bit. A mode input selects one of two paths. In buffered mode every completed conversion is written into the store without any action from the reader. The oldest stored word is always shown at the output (first-word fall-through), and a strobe line read by the host steps through the stored words. In direct mode the newest conversion goes straight to the output, and the store ignores all reads and writes.

A two-bit fill code reports whether the store is empty, partly filled or full. Words that arrive while the store is full are dropped. A read on an empty store leaves the last word in place. Holding the strobe line low while in direct mode empties the store at any time. The mode input and the strobe line are resynchronised in the system clock domain. The fill code is delayed by a fixed register pipeline.

Top module: `sample_fifo_bypass`

## Requirements
- R1: The store holds DEPTH (default 16) words of WORD_W (default 18) bits: bit 17 overflow, bit 16 sign, bits 15:0 data. All 16 words are accepted and returned unchanged, oldest first.
- R2: With `fifo_mode_i` low, `out_word_o` shows the last word given with `conv_valid_i`, and neither conversions nor strobe edges change the stored contents.
- R3: With `fifo_mode_i` high, each cycle with `conv_valid_i` high writes `conv_word_i` into a non-full store, whatever the level of `rd_strobe_i`.
- R4: When a word is written into an empty store, it appears on `out_word_o` and stays there until a rising strobe edge.
- R5: Each rising edge of `rd_strobe_i` in buffered mode presents the next stored word. After a full store, 15 rising edges bring the 16th word to the output.
- R6: A conversion that arrives while the store is full is discarded, and so is every later one until a word has been removed. A discarded word never reaches the output.
- R7: `fill_code_o` is 2'b01 when empty, 2'b11 when full and 2'b00 for 1 to DEPTH-1 words. The value 2'b10 never occurs.
- R8: When a rising edge presents the last stored word, the fill code stays 2'b00. The next falling edge of `rd_strobe_i` makes it 2'b01.
- R9: A rising strobe edge on an empty store leaves `out_word_o` unchanged.
- R10: `fifo_mode_i` low together with `rd_strobe_i` low empties the store at any time. Words written before this are never presented afterwards.
- R11: `rd_strobe_i` and `fifo_mode_i` take effect 3 and 2 clock edges after they change. `fill_code_o` follows a change in fill level after 2 further edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode_i | input | 1 | 1 = buffered path, 0 = direct path |
| rd_strobe_i | input | 1 | Host read line; a rising edge advances, a low level in direct mode empties the store |
| conv_valid_i | input | 1 | One-cycle pulse when a conversion completes |
| conv_word_i | input | 18 | Result word {overflow, sign, data} |
| out_word_o | output | 18 | Word shown to the output register |
| fill_code_o | output | 2 | Fill code: 01 empty, 00 partial, 11 full |

## Verification
A conversion pulse changes the store on the next edge and the output word right after it. A strobe edge passes through two synchroniser stages and one edge-detect register, so it moves the output three edges after the input changes. The fill code trails any change in fill level by two more edges. The bench drives inputs on falling clock edges and normally waits eight cycles before it compares. Around the final read it checks at single-cycle steps: the old value is still present one cycle before each of these due edges, and the new value right after.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
   localparam logic [1:0] FILL_EMPTY = 2'b01;
   localparam logic [1:0] FILL_PART  = 2'b00;
   localparam logic [1:0] FILL_FULL  = 2'b11;

   function automatic logic [1:0] fill_encode(input logic is_empty, input logic is_full);
      if (is_empty)     return FILL_EMPTY;
      else if (is_full) return FILL_FULL;
      else              return FILL_PART;
   endfunction
endpackage

// File: rtl/sfb_delay.sv
module sfb_delay #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] stg;
         for (genvar i = 0; i < STAGES; i++) begin : g_stg
            if (i == 0) begin : g_head
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stg[i] <= RST_VAL;
                  else        stg[i] <= d;
               end
            end else begin : g_body
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stg[i] <= RST_VAL;
                  else        stg[i] <= stg[i-1];
               end
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sfb_store.sv
module sfb_store #(
   parameter int WORD_W = 18,
   parameter int DEPTH  = 16,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/sfb_ctrl.sv
module sfb_ctrl #(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fifo_on,
   input  logic          rd_lvl,
   input  logic          wr_req,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic [AW-1:0] raddr,
   output logic [CW-1:0] count
);
   logic [AW-1:0] wr_ptr_q, rd_ptr_q, wr_nxt, rd_nxt;
   logic [CW-1:0] count_q;
   logic          rd_prev_q, pend_q;
   logic          rise, fall, flush, wr_go, adv, arm, pop_last;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr_q + 1'b1;
         assign rd_nxt = rd_ptr_q + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
         assign rd_nxt = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      end
   endgenerate

   assign rise     = rd_lvl & ~rd_prev_q;
   assign fall     = ~rd_lvl & rd_prev_q;
   assign flush    = ~fifo_on & ~rd_lvl;
   assign wr_go    = fifo_on & wr_req & (count_q != CW'(DEPTH));
   assign adv      = fifo_on & rise & (count_q >= CW'(2));
   assign arm      = fifo_on & rise & ((count_q == CW'(1)) | (count_q == CW'(2)));
   assign pop_last = fifo_on & fall & pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_prev_q <= 1'b1;
         wr_ptr_q  <= '0;
         rd_ptr_q  <= '0;
         count_q   <= '0;
         pend_q    <= 1'b0;
      end else begin
         rd_prev_q <= rd_lvl;
         if (flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
            pend_q   <= 1'b0;
         end else begin
            if (wr_go) wr_ptr_q <= wr_nxt;
            if (adv | pop_last) rd_ptr_q <= rd_nxt;
            count_q <= count_q + CW'(wr_go) - CW'(adv) - CW'(pop_last);
            if (arm)           pend_q <= 1'b1;
            else if (pop_last) pend_q <= 1'b0;
         end
      end
   end

   assign we    = wr_go;
   assign waddr = wr_ptr_q;
   assign raddr = rd_ptr_q;
   assign count = count_q;
endmodule

// File: rtl/sample_fifo_bypass.sv
module sample_fifo_bypass #(
   parameter int DATA_W      = 16,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int MODE_LAT    = 2,
   parameter int STAT_LAT    = 2,
   localparam int WORD_W     = DATA_W + 2,
   localparam int AW         = $clog2(DEPTH),
   localparam int CW         = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_mode_i,
   input  logic              rd_strobe_i,
   input  logic              conv_valid_i,
   input  logic [WORD_W-1:0] conv_word_i,
   output logic [WORD_W-1:0] out_word_o,
   output logic [1:0]        fill_code_o
);
   import sfb_pkg::*;

   generate
      if (DEPTH < 2)       begin : g_bad_depth $error("DEPTH must be at least 2"); end
      if (DATA_W < 1)      begin : g_bad_width $error("DATA_W must be at least 1"); end
      if (SYNC_STAGES < 2) begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
      if (STAT_LAT < 0)    begin : g_bad_stat  $error("STAT_LAT must not be negative"); end
   endgenerate

   logic              fifo_on, rd_lvl, we;
   logic [AW-1:0]     waddr, raddr;
   logic [CW-1:0]     fill_cnt;
   logic [WORD_W-1:0] head, direct_q, last_q;

   sfb_delay #(.W(1), .STAGES(MODE_LAT), .RST_VAL(1'b0)) u_mode_dly (
      .clk(clk), .rst_n(rst_n), .d(fifo_mode_i), .q(fifo_on));

   sfb_delay #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rd_sync (
      .clk(clk), .rst_n(rst_n), .d(rd_strobe_i), .q(rd_lvl));

   sfb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .rd_lvl(rd_lvl),
      .wr_req(conv_valid_i), .we(we), .waddr(waddr), .raddr(raddr),
      .count(fill_cnt));

   sfb_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .we(we), .waddr(waddr), .wdata(conv_word_i),
      .raddr(raddr), .rdata(head));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         direct_q <= '0;
         last_q   <= '0;
      end else begin
         if (conv_valid_i) direct_q <= conv_word_i;
         if (fifo_on && fill_cnt != '0) last_q <= head;
      end
   end

   assign out_word_o = !fifo_on        ? direct_q :
                       (fill_cnt != '0) ? head     : last_q;

   sfb_delay #(.W(2), .STAGES(STAT_LAT), .RST_VAL(FILL_EMPTY)) u_stat_dly (
      .clk(clk), .rst_n(rst_n),
      .d(fill_encode(fill_cnt == '0, fill_cnt == CW'(DEPTH))),
      .q(fill_code_o));
endmodule

// File: rtl/sfb_checker.sv
module sfb_checker #(
   parameter int WORD_W = 18,
   parameter int DEPTH  = 16,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fifo_on,
   input logic              rd_lvl,
   input logic              wr_req,
   input logic [CW-1:0]     count,
   input logic [WORD_W-1:0] out_word,
   input logic [1:0]        fill_code
);
   assert_code_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_code != 2'b10);

   assert_capacity_R1: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   assert_drop_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_on && count == CW'(DEPTH) && wr_req && $stable(rd_lvl)) |=> count == CW'(DEPTH));

   assert_auto_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_on && wr_req && count < CW'(DEPTH) && $stable(rd_lvl))
         |=> count == $past(count) + CW'(1));

   assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_on && !rd_lvl) |=> count == '0);

   assert_direct_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_on && rd_lvl) |=> $stable(count));

   assert_empty_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_on && count == '0 && !wr_req) |=> (!fifo_on || $stable(out_word)));
endmodule

bind sample_fifo_bypass sfb_checker #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .fifo_on(fifo_on), .rd_lvl(rd_lvl),
   .wr_req(conv_valid_i), .count(fill_cnt), .out_word(out_word_o),
   .fill_code(fill_code_o));

// File: tb/sample_fifo_bypass_bench.sv
module sample_fifo_bypass_bench;
   localparam int W = 18;
   localparam int NSTEP = 15;
   localparam logic [2:0] OP_WR = 3'd0, OP_RLO = 3'd1, OP_RHI = 3'd2,
                          OP_MFIFO = 3'd3, OP_MDIR = 3'd4;

   // {op, data, expected word, expected fill code}
   localparam logic [40:0] TBL [NSTEP] = '{
      {OP_MFIFO, 18'h00000, 18'h00000, 2'b01},  // R7 empty code
      {OP_WR,    18'h11111, 18'h11111, 2'b00},  // R4 fall-through
      {OP_WR,    18'h22222, 18'h11111, 2'b00},  // R4 head held
      {OP_RLO,   18'h00000, 18'h11111, 2'b00},  // R5 fall alone does not advance
      {OP_WR,    18'h30003, 18'h11111, 2'b00},  // R3 write with line low
      {OP_RHI,   18'h00000, 18'h22222, 2'b00},  // R5 advance
      {OP_RLO,   18'h00000, 18'h22222, 2'b00},  // R8
      {OP_RHI,   18'h00000, 18'h30003, 2'b00},  // R8 last word, still partial
      {OP_RLO,   18'h00000, 18'h30003, 2'b01},  // R8 fall empties
      {OP_RHI,   18'h00000, 18'h30003, 2'b01},  // R9 read on empty
      {OP_RLO,   18'h00000, 18'h30003, 2'b01},  // R9
      {OP_RHI,   18'h00000, 18'h30003, 2'b01},  // R9
      {OP_MDIR,  18'h00000, 18'h30003, 2'b01},  // R2 direct shows last conversion
      {OP_WR,    18'h0ABCD, 18'h0ABCD, 2'b01},  // R2 not stored
      {OP_MFIFO, 18'h00000, 18'h30003, 2'b01}   // R2 store untouched
   };
   localparam string TAG [NSTEP] = '{"R7", "R4", "R4", "R5", "R3", "R5", "R8",
      "R8", "R8", "R9", "R9", "R9", "R2", "R2", "R2"};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         fifo_mode_i = 1'b0;
   logic         rd_strobe_i = 1'b1;
   logic         conv_valid_i = 1'b0;
   logic [W-1:0] conv_word_i = '0;
   logic [W-1:0] out_word_o;
   logic [1:0]   fill_code_o;
   int           n_chk = 0;
   int           n_err = 0;
   bit           done = 1'b0;

   always #2.5 clk = ~clk;

   sample_fifo_bypass u_sample_fifo_bypass (
      .clk(clk), .rst_n(rst_n), .fifo_mode_i(fifo_mode_i), .rd_strobe_i(rd_strobe_i),
      .conv_valid_i(conv_valid_i), .conv_word_i(conv_word_i),
      .out_word_o(out_word_o), .fill_code_o(fill_code_o));

   task automatic settle(input int n = 8);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_word(input string req, input logic [W-1:0] exp);
      n_chk++;
      if (out_word_o !== exp) begin
         n_err++;
         $display("FAIL %s word: actual %h expected %h", req, out_word_o, exp);
      end
   endtask

   task automatic chk_code(input string req, input logic [1:0] exp);
      n_chk++;
      if (fill_code_o !== exp) begin
         n_err++;
         $display("FAIL %s fill code: actual %b expected %b", req, fill_code_o, exp);
      end
   endtask

   task automatic put(input logic [W-1:0] w);
      conv_valid_i = 1'b1;
      conv_word_i  = w;
      @(negedge clk);
      conv_valid_i = 1'b0;
   endtask

   task automatic apply(input logic [2:0] op, input logic [W-1:0] d);
      case (op)
         OP_WR:    put(d);
         OP_RLO:   rd_strobe_i = 1'b0;
         OP_RHI:   rd_strobe_i = 1'b1;
         OP_MFIFO: fifo_mode_i = 1'b1;
         default:  fifo_mode_i = 1'b0;
      endcase
   endtask

   function automatic logic [W-1:0] fw(input int i);
      return {2'b10, 16'(i * 16'h0101)};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      chk_word("R2", '0);
      chk_code("R7", 2'b01);
      rst_n = 1'b1;
      settle();

      for (int s = 0; s < NSTEP; s++) begin
         apply(TBL[s][40:38], TBL[s][37:20]);
         settle();
         chk_word(TAG[s], TBL[s][19:2]);
         chk_code(TAG[s], TBL[s][1:0]);
      end

      // R1 / R7: fill to capacity
      for (int i = 0; i < 16; i++) put(fw(i));
      settle();
      chk_code("R1", 2'b11);
      chk_word("R1", fw(0));
      // R6: overflow writes dropped
      put(18'h3FFFF);
      put(18'h3FFFF);
      settle();
      chk_code("R6", 2'b11);
      chk_word("R6", fw(0));
      // R5: fifteen rising edges walk through the store
      for (int k = 1; k <= 15; k++) begin
         rd_strobe_i = 1'b0;
         settle();
         rd_strobe_i = 1'b1;
         if (k == 15) begin
            settle(2);
            chk_word("R11", fw(14));
            settle(1);
            chk_word("R11", fw(15));
            settle(5);
         end else begin
            settle();
            chk_word("R5", fw(k));
            if (k == 1) chk_code("R7", 2'b00);
         end
      end
      chk_code("R8", 2'b00);
      rd_strobe_i = 1'b0;
      settle(4);
      chk_code("R11", 2'b00);
      settle(1);
      chk_code("R8", 2'b01);
      settle();
      rd_strobe_i = 1'b1;
      settle();
      chk_word("R6", fw(15));
      chk_code("R9", 2'b01);

      // R10: flush by direct mode with line low
      for (int i = 0; i < 5; i++) put(18'h2A000 + 18'(i));
      settle();
      chk_code("R10", 2'b00);
      rd_strobe_i = 1'b0;
      settle();
      fifo_mode_i = 1'b0;
      settle();
      chk_code("R10", 2'b01);
      rd_strobe_i = 1'b1;
      settle();
      fifo_mode_i = 1'b1;
      settle();
      chk_code("R10", 2'b01);
      put(18'h15555);
      settle();
      chk_word("R10", 18'h15555);
      chk_code("R10", 2'b00);
      rd_strobe_i = 1'b0;
      settle();
      rd_strobe_i = 1'b1;
      settle();
      rd_strobe_i = 1'b0;
      settle();
      chk_word("R10", 18'h15555);
      chk_code("R10", 2'b01);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule